// File: doc/BRIEF.md
# Minimum-cost switching state selector

This block sits at the back end of a finite-set predictive current controller for a three-leg, two-level inverter. Each control period, an upstream unit scores all eight inverter switching states and presents the eight costs at once, together with a one-cycle strobe. The selector finds the cheapest state and reports its cost and its three-bit code. It also produces the six gate commands for the inverter legs and an index number that a monitor can plot.

Selection runs through a pipelined chain of seven compare-and-select stages. Each stage weighs the running minimum against the next cost in turn. The single decision bit of each stage steers two multiplexers: one carries the cost and a parallel one carries the state code. The winning code is then split into one bit per leg. Each bit drives the upper switch of its leg, and the complement of that bit drives the lower switch. A new cost set can be accepted on every clock cycle.

Top module: `minsel_top`

## Requirements
- R1: While reset is applied, and after it until the first result, `out_valid` is 0 and `g_min`, `s_opt`, `index` and all six gate bits are 0. With all gates 0, every switch is off.
- R2: `out_valid` is high for exactly one cycle for each cycle in which `in_valid` was sampled high, 8 clock edges later. Counting the sampling edge as the first, it rises after the 8th edge.
- R3: `g_min` equals the smallest of the eight unsigned costs of the sampled set.
- R4: `s_opt` equals the position k (0 to 7) of that smallest cost, where cost k occupies bits [k*COST_W +: COST_W] of `cost_in`.
- R5: When several costs share the minimum, `s_opt` is the lowest of their positions. For example, when all costs are equal the result is 0.
- R6: `gate[0]`, `gate[2]` and `gate[4]` (the upper switches of legs a, b and c) equal `s_opt[2]`, `s_opt[1]` and `s_opt[0]`.
- R7: Whenever `out_valid` is high, `gate[1]`, `gate[3]` and `gate[5]` (the lower switches) are the inverses of `gate[0]`, `gate[2]` and `gate[4]`.
- R8: `index` equals 4*Sa + 2*Sb + Sc, where Sa, Sb and Sc are `s_opt` bits 2, 1 and 0. State 100 gives 4 and state 010 gives 2.
- R9: In cycles when no result is delivered, `g_min`, `s_opt`, `gate` and `index` keep their last values, whatever `cost_in` does.
- R10: Strobes on consecutive cycles each produce their own correct result on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cost_in | input | 8*COST_W | Eight unsigned costs; cost k at bits [k*COST_W +: COST_W] |
| in_valid | input | 1 | The cost set is valid in this cycle |
| g_min | output | COST_W | Smallest cost of the selected set |
| s_opt | output | 3 | Winning switching state {Sa,Sb,Sc} |
| gate | output | 6 | Gate commands: [0]/[1] leg a upper/lower, [2]/[3] leg b, [4]/[5] leg c |
| index | output | 3 | Monitoring index 4*Sa+2*Sb+Sc |
| out_valid | output | 1 | Result outputs updated in this cycle |

## Verification
A wrong comparator decision or a misrouted state code appears as a mismatch between `g_min` and `s_opt`. It shows on the very strobe that exercises it, 8 cycles after the strobe. The tests therefore put the minimum at the first position, the last position and a middle position, and they include ties that expose a comparison that is not strict. A cost delay line of the wrong length pairs a cost with the wrong set. The back-to-back test exposes this in its second and third results. A slip in the valid pipeline shows at once as a result one cycle early or one cycle late.

// File: rtl/minsel_pkg.sv
// Package: shared sizing for the minimum-cost selector.
// Assumes three inverter legs, so there are 2^3 switching states.
package minsel_pkg;
    parameter int NUM_STATES = 8;
    localparam int STATE_W    = $clog2(NUM_STATES);
    localparam int NUM_STAGES = NUM_STATES - 1;
    localparam int NUM_LEGS   = STATE_W;
    localparam int GATE_W     = 2 * NUM_LEGS;
    localparam int PIPE_LAT   = NUM_STAGES + 1;
endpackage

// File: rtl/minsel_delay.sv
// Module: fixed-length register delay for one cost word.
// It aligns a later cost with the pipeline stage that consumes it.
// Assumes DEPTH >= 1.
module minsel_delay #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] sh [DEPTH];

    // Shift the word one slot per clock; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < DEPTH; m++) sh[m] <= '0;
        end else begin
            sh[0] <= d_in;
            for (int m = 1; m < DEPTH; m++) sh[m] <= sh[m-1];
        end
    end

    assign d_out = sh[DEPTH-1];
endmodule

// File: rtl/minsel_stage.sv
// Module: one compare-and-select pipeline stage.
// The candidate replaces the running minimum only when it is strictly
// smaller, so on a tie the earlier state is kept.
// A single decision bit steers both the cost mux and the state mux.
module minsel_stage #(
    parameter int COST_W = 16,
    parameter int ST_W   = 3,
    parameter int IDX    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [COST_W-1:0] run_i,
    input  logic [ST_W-1:0]   st_i,
    input  logic [COST_W-1:0] cand_i,
    output logic              vld_o,
    output logic [COST_W-1:0] run_o,
    output logic [ST_W-1:0]   st_o
);
    localparam logic [ST_W-1:0] IDX_CODE = ST_W'(IDX);

    logic take;

    // Decision bit: the candidate beats the running minimum.
    always_comb take = (cand_i < run_i);

    // Register the selected cost, the matching state and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            run_o <= '0;
            st_o  <= '0;
        end else begin
            vld_o <= vld_i;
            run_o <= take ? cand_i : run_i;
            st_o  <= take ? IDX_CODE : st_i;
        end
    end

    AST_STAGE_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (run_o <= $past(run_i)) && (run_o <= $past(cand_i))); // R3
    AST_STAGE_TIE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && (cand_i == run_i)) |=> (st_o == $past(st_i))); // R5
endmodule

// File: rtl/minsel_gates.sv
// Module: result register and gate slicer.
// Loads the winner only when a result arrives and holds it otherwise.
// Each state bit drives the upper switch of its leg; the lower switch
// gets the complement. Reset leaves every switch off.
module minsel_gates
    import minsel_pkg::*;
#(
    parameter int COST_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld_i,
    input  logic [COST_W-1:0]  run_i,
    input  logic [STATE_W-1:0] st_i,
    output logic [COST_W-1:0]  g_min_o,
    output logic [STATE_W-1:0] s_opt_o,
    output logic [GATE_W-1:0]  gate_o,
    output logic [STATE_W-1:0] index_o,
    output logic               vld_o
);
    logic [GATE_W-1:0]  gate_nx;
    logic [STATE_W-1:0] index_nx;

    // Split the state into leg commands and weight its bits into the index.
    always_comb begin
        index_nx = '0;
        for (int l = 0; l < NUM_LEGS; l++) begin
            gate_nx[2*l]   =  st_i[NUM_LEGS-1-l];
            gate_nx[2*l+1] = ~st_i[NUM_LEGS-1-l];
            index_nx = index_nx + (STATE_W'(st_i[NUM_LEGS-1-l]) << (NUM_LEGS-1-l));
        end
    end

    // Capture the result on a valid cycle; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_min_o <= '0;
            s_opt_o <= '0;
            gate_o  <= '0;
            index_o <= '0;
            vld_o   <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                g_min_o <= run_i;
                s_opt_o <= st_i;
                gate_o  <= gate_nx;
                index_o <= index_nx;
            end
        end
    end

    AST_GATE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ((gate_o[1] == !gate_o[0]) && (gate_o[3] == !gate_o[2])
                   && (gate_o[5] == !gate_o[4]))); // R7
    AST_UPPER_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ({gate_o[0], gate_o[2], gate_o[4]} == s_opt_o)); // R6
    AST_INDEX_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (index_o == {gate_o[0], gate_o[2], gate_o[4]})); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(gate_o) && $stable(s_opt_o) && $stable(g_min_o))); // R9
    AST_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(vld_i)); // R2
endmodule

// File: rtl/minsel_top.sv
// Module: minimum-cost switching state selector.
// Cost 0 seeds the chain. Stage k compares cost k+1, delayed by k cycles
// so that it meets its stage in step with the running minimum.
// Latency is PIPE_LAT cycles, and a new set can enter every cycle.
module minsel_top
    import minsel_pkg::*;
#(
    parameter int COST_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_STATES*COST_W-1:0] cost_in,
    input  logic                         in_valid,
    output logic [COST_W-1:0]            g_min,
    output logic [STATE_W-1:0]           s_opt,
    output logic [GATE_W-1:0]            gate,
    output logic [STATE_W-1:0]           index,
    output logic                         out_valid
);
    logic              vld_p [NUM_STAGES+1];
    logic [COST_W-1:0] run_p [NUM_STAGES+1];
    logic [STATE_W-1:0] st_p [NUM_STAGES+1];
    logic [COST_W-1:0] cand  [NUM_STAGES];

    assign vld_p[0] = in_valid;
    assign run_p[0] = cost_in[COST_W-1:0];
    assign st_p[0]  = '0;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_chain
        if (k == 0) begin : g_direct
            assign cand[k] = cost_in[COST_W +: COST_W];
        end else begin : g_delayed
            minsel_delay #(.WIDTH(COST_W), .DEPTH(k)) dly_i (
                .clk   (clk),
                .rst_n (rst_n),
                .d_in  (cost_in[(k+1)*COST_W +: COST_W]),
                .d_out (cand[k])
            );
        end

        minsel_stage #(.COST_W(COST_W), .ST_W(STATE_W), .IDX(k+1)) stg_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (vld_p[k]),
            .run_i  (run_p[k]),
            .st_i   (st_p[k]),
            .cand_i (cand[k]),
            .vld_o  (vld_p[k+1]),
            .run_o  (run_p[k+1]),
            .st_o   (st_p[k+1])
        );
    end

    minsel_gates #(.COST_W(COST_W)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (vld_p[NUM_STAGES]),
        .run_i   (run_p[NUM_STAGES]),
        .st_i    (st_p[NUM_STAGES]),
        .g_min_o (g_min),
        .s_opt_o (s_opt),
        .gate_o  (gate),
        .index_o (index),
        .vld_o   (out_valid)
    );
endmodule

// File: tb/minsel_top_tb_top.sv
// Bench: directed scenarios for the minimum-cost selector.
module minsel_top_tb_top;
    import minsel_pkg::*;
    localparam int CW = 16;
    localparam int NS = NUM_STATES;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NS*CW-1:0]     cost_in = '0;
    logic                 in_valid = 1'b0;
    logic [CW-1:0]        g_min;
    logic [STATE_W-1:0]   s_opt;
    logic [GATE_W-1:0]    gate;
    logic [STATE_W-1:0]   index;
    logic                 out_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    minsel_top #(.COST_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cost_in(cost_in), .in_valid(in_valid),
        .g_min(g_min), .s_opt(s_opt), .gate(gate), .index(index),
        .out_valid(out_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: strict minimum, lowest position on ties (R3 R4 R5).
    function automatic int ref_pos(input logic [NS*CW-1:0] c);
        int p = 0;
        for (int k = 1; k < NS; k++)
            if (c[k*CW +: CW] < c[p*CW +: CW]) p = k;
        return p;
    endfunction

    function automatic int ref_gates(input int s);
        int g = 0;
        for (int l = 0; l < 3; l++) begin
            int b = (s >> (2 - l)) & 1;
            g |= b << (2*l);
            g |= (1 - b) << (2*l + 1);
        end
        return g;
    endfunction

    task automatic check_result(input logic [NS*CW-1:0] c, input string tag);
        int p = ref_pos(c);
        chk({tag, " R2 out_valid"}, int'(out_valid), 1);
        chk({tag, " R3 g_min"}, int'(g_min), int'(c[p*CW +: CW]));
        chk({tag, " R4 R5 s_opt"}, int'(s_opt), p);
        chk({tag, " R6 R7 gate"}, int'(gate), ref_gates(p));
        chk({tag, " R8 index"}, int'(index), 4*((p>>2)&1) + 2*((p>>1)&1) + (p&1));
    endtask

    // One set: strobe at one negedge, result checked 8 clock edges later.
    task automatic run_one(input logic [NS*CW-1:0] c, input string tag);
        cost_in = c; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0; cost_in = ~c;
        repeat (6) @(negedge clk);
        chk({tag, " R2 early"}, int'(out_valid), 0);
        @(negedge clk);
        check_result(c, tag);
        @(negedge clk);
        chk({tag, " R2 single"}, int'(out_valid), 0);
    endtask

    function automatic logic [NS*CW-1:0] mk(input int a0, a1, a2, a3, a4, a5, a6, a7);
        logic [NS*CW-1:0] v;
        v[0*CW +: CW] = CW'(a0); v[1*CW +: CW] = CW'(a1);
        v[2*CW +: CW] = CW'(a2); v[3*CW +: CW] = CW'(a3);
        v[4*CW +: CW] = CW'(a4); v[5*CW +: CW] = CW'(a5);
        v[6*CW +: CW] = CW'(a6); v[7*CW +: CW] = CW'(a7);
        return v;
    endfunction

    task automatic t_reset;
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 gate", int'(gate), 0);
        chk("R1 s_opt", int'(s_opt), 0);
        chk("R1 g_min", int'(g_min), 0);
        chk("R1 index", int'(index), 0);
    endtask

    task automatic t_patterns;
        run_one(mk(3, 9, 9, 9, 9, 9, 9, 9), "first");
        run_one(mk(50, 40, 30, 20, 15, 12, 11, 2), "last");
        run_one(mk(70, 60, 80, 60, 5, 90, 8, 70), "mid4");
        run_one(mk(70, 60, 4, 60, 50, 90, 8, 70), "mid2");
        run_one(mk(65535, 65535, 65535, 65535, 65535, 65534, 65535, 65535), "wide");
    endtask

    task automatic t_ties;
        run_one(mk(7, 7, 7, 7, 7, 7, 7, 7), "all_equal R5");
        run_one(mk(0, 5, 5, 5, 5, 5, 5, 0), "zero_vec R5");
        run_one(mk(9, 9, 9, 1, 9, 9, 1, 9), "pair R5");
    endtask

    // R9: after a result, drive new costs without a strobe; outputs hold.
    task automatic t_hold;
        int g0 = int'(gate), s0 = int'(s_opt), m0 = int'(g_min), i0 = int'(index);
        for (int n = 0; n < 12; n++) begin
            cost_in = mk(n, 1, 2, 3, 4, 5, 6, 0);
            @(negedge clk);
        end
        chk("R9 gate held", int'(gate), g0);
        chk("R9 s_opt held", int'(s_opt), s0);
        chk("R9 g_min held", int'(g_min), m0);
        chk("R9 index held", int'(index), i0);
    endtask

    // R10: three sets on consecutive cycles.
    task automatic t_back2back;
        logic [NS*CW-1:0] v [3];
        v[0] = mk(9, 8, 7, 6, 5, 4, 3, 1);
        v[1] = mk(2, 8, 7, 6, 5, 4, 3, 9);
        v[2] = mk(9, 8, 7, 0, 5, 4, 3, 9);
        for (int j = 0; j < 3; j++) begin
            cost_in = v[j]; in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0; cost_in = '0;
        repeat (4) @(negedge clk);
        chk("R10 R2 early", int'(out_valid), 0);
        @(negedge clk);
        for (int j = 0; j < 3; j++) begin
            check_result(v[j], "R10 seq");
            @(negedge clk);
        end
        chk("R10 R2 end", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_patterns;
        t_ties;
        t_hold;
        t_back2back;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule